// File: doc/BRIEF.md
# Configurable Parallel Port Unit

This block is a Wishbone slave that gives a host processor one, two or four parallel ports, each 8, 16 or 32 bits wide. Three build-time types are offered. An output-only unit holds one output register per port. An input/output unit adds an input bus per port, which the host reads. A tristate unit adds, for each port, a second register whose value is driven out on its own bus, meant to steer external buffers when a pin must be bidirectional.

The tristate-control registers are plain storage. They touch neither the port output nor the input path, so a design may also use them as extra output-only ports. The register count, and with it the width of the address input, follows from the port count and the type. Only single classic Wishbone cycles are served: no bursts, no byte selects, no interrupts.

All port buses are packed side by side, port A in the lowest slice, then B, C and D. Port `p` occupies bits `[p*DATA_W +: DATA_W]`.

Top module: `pport_unit`

## Requirements
- R1: A transfer is accepted on a rising clock edge where `busCyc` and `busStb` are both 1 and `busAck` is 0. `busAck` is 1 for exactly the one cycle after that edge. With the request held, it alternates 1, 0, 1, 0.
- R2: While `rst` is 1 on a rising edge, all port output and tristate-control registers, `busAck` and `busDatOut` are cleared to zero.
- R3: In output-only and input/output types, address n selects port n. In the tristate type, address 2n selects the port register of port n and address 2n+1 selects its tristate-control register. The address width is ceil(log2(register count)), with a minimum of 1. A unit with a single register ignores the address.
- R4: On an accepted transfer with `busWe` = 1, the selected register loads `busDatIn`, and the new value appears together with `busAck`. Port and tristate-control outputs change on no other occasion.
- R5: On an accepted transfer with `busWe` = 0, the selected value appears on `busDatOut` during the `busAck` cycle. At all other times `busDatOut` is zero.
- R6: In input/output and tristate types, a read of a port address returns that port's input bus, captured by a register on every clock edge.
- R7: In the output-only type, a read of a port address returns that port's output register.
- R8: A read of a tristate-control address returns that register. Writing it changes only its own `dirOut` slice and never `portOut` or a port read.
- R9: `dirOut` is all zero in output-only and input/output types.
- R10: A write presented with `busStb` = 0 or with `busCyc` = 0 changes no register and raises no `busAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| busCyc | input | 1 | Bus cycle valid |
| busStb | input | 1 | Transfer strobe |
| busWe | input | 1 | 1 = write, 0 = read |
| busAdr | input | ADDR_W | Register select, width from port count and type |
| busDatIn | input | DATA_W | Write data from host |
| busDatOut | output | DATA_W | Read data to host, valid with busAck |
| busAck | output | 1 | Transfer complete, one cycle |
| portIn | input | NUM_PORTS*DATA_W | Port input buses, packed A upward |
| portOut | output | NUM_PORTS*DATA_W | Port output buses, packed A upward |
| dirOut | output | NUM_PORTS*DATA_W | Tristate-control buses, packed A upward |

## Verification
The hardest case to reach from the ports is proving that the tristate-control registers are independent. Both registers of one port have to hold different, non-trivial values, and a port read has to be made while the input bus differs from both. The stimulus writes a distinct pattern into every one of the eight registers and drives an input pattern unlike any of them. It then reads every address, while the reference model compares `portOut`, `dirOut`, `busAck` and `busDatOut` on every clock. A second unit built as output-only and a third built with a single register share one host bus, so a single write sequence also shows that the address is ignored when only one register exists.

// File: rtl/pport_pkg.sv
package pport_pkg;

  typedef enum logic [1:0] {
    KIND_OUT = 2'd0,
    KIND_IO  = 2'd1,
    KIND_TRI = 2'd2
  } portKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wr;
    logic rd;
  } busStrobe_t;

  function automatic int regCount(int ports, portKind_e kind);
    return (kind == KIND_TRI) ? 2 * ports : ports;
  endfunction

  function automatic int addrBits(int ports, portKind_e kind);
    int n;
    n = regCount(ports, kind);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/pport_ctrl.sv
module pport_ctrl (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  busCyc,
  input  logic                  busStb,
  input  logic                  busWe,
  output pport_pkg::busStrobe_t strobe,
  output logic                  busAck
);
  logic ackReg;
  logic request;

  // a new transfer is taken only when no acknowledge is pending
  assign request    = busCyc & busStb & ~ackReg;
  assign strobe.wr  = request & busWe;
  assign strobe.rd  = request & ~busWe;

  always_ff @(posedge clk) begin
    if (rst) ackReg <= 1'b0;
    else     ackReg <= request;
  end

  assign busAck = ackReg;
endmodule

// File: rtl/pport_datapath.sv
module pport_datapath #(
  parameter int                   NUM_PORTS = 4,
  parameter int                   DATA_W    = 8,
  parameter pport_pkg::portKind_e PORT_KIND = pport_pkg::KIND_TRI,
  parameter int                   ADDR_W    = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  pport_pkg::busStrobe_t         strobe,
  input  logic [ADDR_W-1:0]             busAdr,
  input  logic [DATA_W-1:0]             busDatIn,
  output logic [DATA_W-1:0]             busDatOut,
  input  logic [NUM_PORTS*DATA_W-1:0]   portIn,
  output logic [NUM_PORTS*DATA_W-1:0]   portOut,
  output logic [NUM_PORTS*DATA_W-1:0]   dirOut
);
  localparam bit IS_TRI = (PORT_KIND == pport_pkg::KIND_TRI);
  localparam bit HAS_IN = (PORT_KIND != pport_pkg::KIND_OUT);
  localparam int SHIFT  = IS_TRI ? 1 : 0;
  localparam int IDX_W  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  logic [DATA_W-1:0] outArr  [NUM_PORTS];
  logic [DATA_W-1:0] dirArr  [NUM_PORTS];
  logic [DATA_W-1:0] inArr   [NUM_PORTS];
  logic [DATA_W-1:0] viewArr [NUM_PORTS];
  logic [IDX_W-1:0]  portSel;
  logic              selDir;
  logic [DATA_W-1:0] rdVal;

  // address decode: tristate type interleaves port and direction registers
  always_comb begin
    selDir  = IS_TRI ? busAdr[0] : 1'b0;
    portSel = IDX_W'(busAdr >> SHIFT);
    if (NUM_PORTS == 1) portSel = '0;
  end

  for (genvar g = 0; g < NUM_PORTS; g++) begin : gPort
    logic [DATA_W-1:0] outReg;
    logic [DATA_W-1:0] inReg;

    always_ff @(posedge clk) begin
      if (rst)                                              outReg <= '0;
      else if (strobe.wr && !selDir && portSel == IDX_W'(g)) outReg <= busDatIn;
    end

    // input bus captured every clock, no reset needed
    always_ff @(posedge clk) inReg <= portIn[g*DATA_W +: DATA_W];

    assign outArr[g] = outReg;
    assign inArr[g]  = inReg;
    assign portOut[g*DATA_W +: DATA_W] = outReg;

    if (HAS_IN) begin : gIn
      assign viewArr[g] = inReg;
    end else begin : gNoIn
      assign viewArr[g] = outReg;
    end

    if (IS_TRI) begin : gDir
      logic [DATA_W-1:0] dirReg;
      always_ff @(posedge clk) begin
        if (rst)                                             dirReg <= '0;
        else if (strobe.wr && selDir && portSel == IDX_W'(g)) dirReg <= busDatIn;
      end
      assign dirArr[g] = dirReg;
    end else begin : gNoDir
      assign dirArr[g] = '0;
    end

    assign dirOut[g*DATA_W +: DATA_W] = dirArr[g];
  end

  assign rdVal = selDir ? dirArr[portSel] : viewArr[portSel];

  always_ff @(posedge clk) begin
    if (rst)            busDatOut <= '0;
    else if (strobe.rd) busDatOut <= rdVal;
    else                busDatOut <= '0;
  end
endmodule

// File: rtl/pport_unit.sv
module pport_unit #(
  parameter int                   NUM_PORTS = 4,
  parameter int                   DATA_W    = 8,
  parameter pport_pkg::portKind_e PORT_KIND = pport_pkg::KIND_TRI
) (
  input  logic                                              clk,
  input  logic                                              rst,
  input  logic                                              busCyc,
  input  logic                                              busStb,
  input  logic                                              busWe,
  input  logic [pport_pkg::addrBits(NUM_PORTS, PORT_KIND)-1:0] busAdr,
  input  logic [DATA_W-1:0]                                 busDatIn,
  output logic [DATA_W-1:0]                                 busDatOut,
  output logic                                              busAck,
  input  logic [NUM_PORTS*DATA_W-1:0]                       portIn,
  output logic [NUM_PORTS*DATA_W-1:0]                       portOut,
  output logic [NUM_PORTS*DATA_W-1:0]                       dirOut
);
  localparam int ADDR_W = pport_pkg::addrBits(NUM_PORTS, PORT_KIND);

  pport_pkg::busStrobe_t strobe;

  pport_ctrl uCtrl (
    .clk    (clk),
    .rst    (rst),
    .busCyc (busCyc),
    .busStb (busStb),
    .busWe  (busWe),
    .strobe (strobe),
    .busAck (busAck)
  );

  pport_datapath #(
    .NUM_PORTS (NUM_PORTS),
    .DATA_W    (DATA_W),
    .PORT_KIND (PORT_KIND),
    .ADDR_W    (ADDR_W)
  ) uPath (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .busAdr    (busAdr),
    .busDatIn  (busDatIn),
    .busDatOut (busDatOut),
    .portIn    (portIn),
    .portOut   (portOut),
    .dirOut    (dirOut)
  );
endmodule

// File: rtl/pport_checker.sv
module pport_checker #(
  parameter int PW     = 32,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              busCyc,
  input logic              busStb,
  input logic              busWe,
  input logic              busAck,
  input logic [DATA_W-1:0] busDatOut,
  input logic [PW-1:0]     portOut,
  input logic [PW-1:0]     dirOut
);
  // R1: acknowledge lasts one cycle
  a_r1_ack_single: assert property (@(posedge clk) disable iff (rst)
    busAck |=> !busAck);

  // R1: acknowledge only follows a request
  a_r1_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
    busAck |-> $past(busCyc && busStb));

  // R2: first cycle after reset shows cleared outputs
  a_r2_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (portOut == '0 && dirOut == '0 && !busAck));

  // R4 / R10: outputs move only on an accepted write
  a_r4_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    !(busCyc && busStb && busWe && !busAck) |=> ($stable(portOut) && $stable(dirOut)));

  // R5: read data is zero outside the acknowledge cycle
  a_r5_data_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !busAck |-> busDatOut == '0);
endmodule

bind pport_unit pport_checker #(
  .PW     (NUM_PORTS * DATA_W),
  .DATA_W (DATA_W)
) uChk (
  .clk       (clk),
  .rst       (rst),
  .busCyc    (busCyc),
  .busStb    (busStb),
  .busWe     (busWe),
  .busAck    (busAck),
  .busDatOut (busDatOut),
  .portOut   (portOut),
  .dirOut    (dirOut)
);

// File: tb/sim_pport_unit.sv
`timescale 1ns/1ps
module sim_pport_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  bit started = 1'b0;

  // unit 0: 4 ports, 8 bits, tristate
  logic        cyc0 = 0, stb0 = 0, we0 = 0;
  logic [2:0]  adr0 = '0;
  logic [7:0]  din0 = '0;
  logic [31:0] pin0 = '0;
  logic [7:0]  dout0;
  logic        ack0;
  logic [31:0] pout0, dir0;

  // units 1 and 2 share one host bus
  logic        cyc1 = 0, stb1 = 0, we1 = 0;
  logic [0:0]  adr1 = '0;
  logic [31:0] din1 = '0;
  logic [31:0] pin1 = 32'h5A5A_0F0F;
  logic [15:0] dout1;
  logic        ack1;
  logic [31:0] pout1, dir1;
  logic [31:0] dout2, pout2, dir2;
  logic        ack2;

  pport_unit u0 (
    .clk(clk), .rst(rst), .busCyc(cyc0), .busStb(stb0), .busWe(we0),
    .busAdr(adr0), .busDatIn(din0), .busDatOut(dout0), .busAck(ack0),
    .portIn(pin0), .portOut(pout0), .dirOut(dir0));

  pport_unit #(.NUM_PORTS(2), .DATA_W(16), .PORT_KIND(pport_pkg::KIND_OUT)) u1 (
    .clk(clk), .rst(rst), .busCyc(cyc1), .busStb(stb1), .busWe(we1),
    .busAdr(adr1), .busDatIn(din1[15:0]), .busDatOut(dout1), .busAck(ack1),
    .portIn(pin1), .portOut(pout1), .dirOut(dir1));

  pport_unit #(.NUM_PORTS(1), .DATA_W(32), .PORT_KIND(pport_pkg::KIND_OUT)) u2 (
    .clk(clk), .rst(rst), .busCyc(cyc1), .busStb(stb1), .busWe(we1),
    .busAdr(adr1), .busDatIn(din1), .busDatOut(dout2), .busAck(ack2),
    .portIn(pin1), .portOut(pout2), .dirOut(dir2));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model of unit 0
  logic [7:0] mOut [4];
  logic [7:0] mDir [4];
  logic [7:0] mIn  [4];
  logic       mAck;
  logic [7:0] mDat;

  always @(posedge clk) begin
    logic req;
    int   p;
    started = 1'b1;
    if (rst) begin
      mAck = 1'b0;
      mDat = '0;
      for (int i = 0; i < 4; i++) begin mOut[i] = '0; mDir[i] = '0; end
    end else begin
      req  = cyc0 && stb0 && !mAck;
      p    = int'(adr0) / 2;
      mDat = '0;
      if (req && we0) begin
        if (adr0[0]) mDir[p] = din0; else mOut[p] = din0;
      end else if (req) begin
        mDat = adr0[0] ? mDir[p] : mIn[p];
      end
      mAck = req;
    end
    for (int i = 0; i < 4; i++) mIn[i] = pin0[i*8 +: 8];
  end

  always @(negedge clk) begin
    if (started) begin
      check("R1 ack", {31'b0, ack0}, {31'b0, mAck});
      check("R5 read data", {24'b0, dout0}, {24'b0, mDat});
      check("R4 portOut", pout0, {mOut[3], mOut[2], mOut[1], mOut[0]});
      check("R8 dirOut", dir0, {mDir[3], mDir[2], mDir[1], mDir[0]});
    end
  end

  task automatic xfer0(input logic w, input logic [2:0] a, input logic [7:0] d,
                       output logic [7:0] rd);
    @(negedge clk);
    cyc0 = 1; stb0 = 1; we0 = w; adr0 = a; din0 = d;
    @(negedge clk);
    check("R1 ack on transfer", {31'b0, ack0}, 32'd1);
    rd = dout0;
    cyc0 = 0; stb0 = 0; we0 = 0;
  endtask

  task automatic xfer1(input logic w, input logic a, input logic [31:0] d,
                       output logic [15:0] rd1, output logic [31:0] rd2);
    @(negedge clk);
    cyc1 = 1; stb1 = 1; we1 = w; adr1 = a; din1 = d;
    @(negedge clk);
    check("R1 ack unit1", {31'b0, ack1}, 32'd1);
    check("R1 ack unit2", {31'b0, ack2}, 32'd1);
    rd1 = dout1; rd2 = dout2;
    cyc1 = 0; stb1 = 0; we1 = 0;
  endtask

  initial begin
    logic [7:0]  r;
    logic [15:0] r1;
    logic [31:0] r2;
    logic [31:0] snap;
    repeat (3) @(negedge clk);
    check("R2 reset portOut", pout0, '0);
    check("R2 reset dirOut", dir0, '0);
    check("R2 reset ack", {31'b0, ack0}, '0);
    check("R2 reset unit1", pout1, '0);
    rst = 0;

    // fill every register of unit 0 with a distinct value
    for (int a = 0; a < 8; a++) xfer0(1'b1, 3'(a), 8'(8'h13 + a * 8'h22), r);
    check("R3 port A at addr 0", {24'b0, pout0[7:0]}, 32'h13);
    check("R3 port D at addr 6", {24'b0, pout0[31:24]}, 32'h13 + 6 * 32'h22);
    check("R8 dir B at addr 3", {24'b0, dir0[15:8]}, 32'h13 + 3 * 32'h22);

    // input pattern unlike any register
    @(negedge clk); pin0 = 32'hA5C3_3C5A;
    for (int p = 0; p < 4; p++) begin
      xfer0(1'b0, 3'(2 * p), 8'h00, r);
      check("R6 port read returns input", {24'b0, r}, {24'b0, pin0[p*8 +: 8]});
      xfer0(1'b0, 3'(2 * p + 1), 8'h00, r);
      check("R8 dir read", {24'b0, r}, 32'(8'(8'h13 + (2 * p + 1) * 8'h22)));
    end

    // R10: incomplete requests
    snap = pout0;
    @(negedge clk); cyc0 = 1; stb0 = 0; we0 = 1; adr0 = 0; din0 = 8'hEE;
    repeat (3) @(negedge clk);
    check("R10 no ack without stb", {31'b0, ack0}, '0);
    cyc0 = 0; stb0 = 1;
    repeat (3) @(negedge clk);
    check("R10 no ack without cyc", {31'b0, ack0}, '0);
    check("R10 portOut unchanged", pout0, snap);
    stb0 = 0; we0 = 0;

    // R1: held request gives alternating ack
    @(negedge clk); cyc0 = 1; stb0 = 1; we0 = 0; adr0 = 3'd2;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R1 held request pattern", {31'b0, ack0}, (k % 2 == 0) ? 32'd1 : 32'd0);
    end
    cyc0 = 0; stb0 = 0;

    // units 1 and 2
    xfer1(1'b1, 1'b0, 32'h7777_1234, r1, r2);
    xfer1(1'b1, 1'b1, 32'hCAFE_BEEF, r1, r2);
    check("R7 unit1 portOut", pout1, 32'hBEEF_1234);
    check("R9 unit1 dirOut zero", dir1, '0);
    check("R3 single register ignores address", pout2, 32'hCAFE_BEEF);
    check("R9 unit2 dirOut zero", dir2, '0);
    xfer1(1'b0, 1'b0, 32'h0, r1, r2);
    check("R7 unit1 read port A returns output reg", {16'b0, r1}, 32'h1234);
    check("R3 unit2 read at addr 0", r2, 32'hCAFE_BEEF);
    xfer1(1'b0, 1'b1, 32'h0, r1, r2);
    check("R7 unit1 read port B returns output reg", {16'b0, r1}, 32'hBEEF);

    // R2: reset in the middle of operation
    @(negedge clk); rst = 1;
    @(negedge clk);
    check("R2 mid-run reset portOut", pout0, '0);
    check("R2 mid-run reset dirOut", dir0, '0);
    check("R2 mid-run reset unit2", pout2, '0);
    rst = 0;
    repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule